// File: doc/BRIEF.md
# Mixed-Width Simple Dual-Port RAM

This block is a small on-chip memory with a fixed bit budget. It has one port that only writes and one port that only reads, and both work on the same clock. Each port picks its own data width when the design is elaborated. The write side can therefore store words of one width while the read side fetches words of another width from the same bits. Narrow views of wide words follow a fixed little-endian rule: the lowest narrow address maps to the least significant slice. A read takes one cycle, and the output register keeps its value until the next enabled read.

There are two width families. The data-only widths 1, 2, 4, 8 and 16 cover 512 bits, and any of them can pair with any other. The parity-extended widths 9 and 18 cover all 576 bits. Each of them is legal only when both ports use it. Any other pairing stops elaboration with an error.

Top module: `mwram`

## Requirements
- R1: The port widths WR_W and RD_W must each be in {1,2,4,8,16}, or both must equal 9, or both must equal 18. The package function `pair_ok` returns 1 exactly for these pairings, and any other pairing raises an elaboration error.
- R2: A port of width w has 512/w addresses for data-only widths and 576/w addresses for widths 9 and 18. The highest address of each port can be written and read.
- R3: Address a on a port of width w covers flat bits [a*w +: w] of one shared bit array. Inside a wide word, lower narrow addresses map to less significant bits.
- R4: Data written at the write width reads back unchanged at the read width over the same flat bits.
- R5: A write that is narrower than the read word changes only its own slice. The other bits of the wide word keep their values.
- R6: While wr_en is low, the memory does not change, whatever wr_addr and wr_data carry.
- R7: A read with rd_en high is captured at the clock edge. rd_data shows the result after that edge and not before.
- R8: While rd_en is low, rd_data holds its value, even if rd_addr changes or the held bits are overwritten.
- R9: A read whose bits are written in the same cycle returns the contents from before that write. The next read returns the new contents.
- R10: A synchronous, active-high rst clears rd_data to zero. It does not alter the stored contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ports |
| rst | input | 1 | Synchronous active-high reset of the read register |
| wr_en | input | 1 | Write enable |
| wr_addr | input | $clog2(bits/WR_W) | Write address at the write width |
| wr_data | input | WR_W | Write data |
| rd_en | input | 1 | Read enable |
| rd_addr | input | $clog2(bits/RD_W) | Read address at the read width |
| rd_data | output | RD_W | Registered read data |

## Verification
A write and a read can land on the same bits in one cycle. The bench provokes this by writing the top write address while it reads the read address that covers that address's first flat bit. The value returned must equal the flat reference model from before the write, and a second read must show the new bits. A hold check also overwrites the bits behind a held output while rd_en is low, and the output must not move.

// File: rtl/mwram_pkg.sv
`timescale 1ns/1ps
package mwram_pkg;

    localparam int FULL_BITS = 576;
    localparam int DATA_BITS = 512;

    typedef enum logic [1:0] {
        CFG_DATA   = 2'd0,
        CFG_PARITY = 2'd1,
        CFG_BAD    = 2'd2
    } cfg_mode_t;

    function automatic bit width_is_data(input int w);
        return (w == 1) || (w == 2) || (w == 4) || (w == 8) || (w == 16);
    endfunction

    function automatic bit width_is_par(input int w);
        return (w == 9) || (w == 18);
    endfunction

    function automatic cfg_mode_t mode_of(input int w, input int r);
        if (width_is_data(w) && width_is_data(r)) return CFG_DATA;
        if (width_is_par(w) && (w == r))          return CFG_PARITY;
        return CFG_BAD;
    endfunction

    function automatic bit pair_ok(input int w, input int r);
        return mode_of(w, r) != CFG_BAD;
    endfunction

    function automatic int array_bits(input int w, input int r);
        return (mode_of(w, r) == CFG_PARITY) ? FULL_BITS : DATA_BITS;
    endfunction

    function automatic int max_w(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/mwram_wr_lane.sv
`timescale 1ns/1ps
module mwram_wr_lane #(
    parameter int W    = 4,
    parameter int WIDE = 16,
    parameter int AW   = 7,
    parameter int IW   = 5
) (
    input  logic [AW-1:0]   addr,
    input  logic [W-1:0]    data,
    output logic [IW-1:0]   idx,
    output logic [WIDE-1:0] mask,
    output logic [WIDE-1:0] bits
);
    localparam int RATIO = WIDE / W;

    generate
        if (RATIO == 1) begin : g_full
            assign idx  = addr;
            assign mask = '1;
            assign bits = data;
        end else begin : g_slice
            localparam int SW = $clog2(RATIO);
            localparam logic [WIDE-1:0] LANE_ONES = WIDE'({W{1'b1}});
            logic [SW-1:0] sub;
            assign idx  = addr[AW-1:SW];
            assign sub  = addr[SW-1:0];
            assign mask = LANE_ONES << (int'(sub) * W);
            assign bits = WIDE'(data) << (int'(sub) * W);
        end
    endgenerate

endmodule

// File: rtl/mwram_store.sv
`timescale 1ns/1ps
module mwram_store #(
    parameter int WIDE  = 16,
    parameter int DEPTH = 32,
    parameter int IW    = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [IW-1:0]   widx,
    input  logic [WIDE-1:0] wmask,
    input  logic [WIDE-1:0] wbits,
    input  logic [IW-1:0]   ridx,
    output logic [WIDE-1:0] rword
);
    logic [WIDE-1:0] mem [DEPTH];
    logic [WIDE-1:0] cur_w;

    assign cur_w = mem[widx];
    assign rword = mem[ridx];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[widx] <= (cur_w & ~wmask) | (wbits & wmask);
        end
    end

    AST_WR_SLICE_ONLY: assert property (@(posedge clk) disable iff (rst)
        we |=> (((mem[$past(widx)] ^ $past(cur_w)) & ~$past(wmask)) == '0)); // R5

    AST_WR_LANDS: assert property (@(posedge clk) disable iff (rst)
        we |=> ((mem[$past(widx)] & $past(wmask)) == ($past(wbits) & $past(wmask)))); // R4

    AST_WR_OFF_KEEPS: assert property (@(posedge clk) disable iff (rst)
        !we |=> (mem[$past(widx)] == $past(cur_w))); // R6

endmodule

// File: rtl/mwram_rd_port.sv
`timescale 1ns/1ps
module mwram_rd_port #(
    parameter int R    = 16,
    parameter int WIDE = 16,
    parameter int AW   = 5,
    parameter int IW   = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            re,
    input  logic [AW-1:0]   addr,
    output logic [IW-1:0]   idx,
    input  logic [WIDE-1:0] rword,
    output logic [R-1:0]    rdata
);
    localparam int RATIO = WIDE / R;

    logic [R-1:0] slice;

    generate
        if (RATIO == 1) begin : g_full
            assign idx   = addr;
            assign slice = rword;
        end else begin : g_slice
            localparam int SW = $clog2(RATIO);
            logic [SW-1:0] sub;
            assign idx   = addr[AW-1:SW];
            assign sub   = addr[SW-1:0];
            assign slice = rword[int'(sub) * R +: R];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= slice;
        end
    end

    AST_RST_ZERO: assert property (@(posedge clk)
        rst |=> (rdata == '0)); // R10

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!re && !$past(rst)) |=> $stable(rdata)); // R8

endmodule

// File: rtl/mwram.sv
`timescale 1ns/1ps
module mwram
    import mwram_pkg::*;
#(
    parameter int WR_W = 4,
    parameter int RD_W = 16
) (
    input  logic                                                   clk,
    input  logic                                                   rst,
    input  logic                                                   wr_en,
    input  logic [$clog2(array_bits(WR_W, RD_W) / WR_W)-1:0]       wr_addr,
    input  logic [WR_W-1:0]                                        wr_data,
    input  logic                                                   rd_en,
    input  logic [$clog2(array_bits(WR_W, RD_W) / RD_W)-1:0]       rd_addr,
    output logic [RD_W-1:0]                                        rd_data
);
    localparam cfg_mode_t MODE  = mode_of(WR_W, RD_W);
    localparam int        TOT   = array_bits(WR_W, RD_W);
    localparam int        WIDE  = max_w(WR_W, RD_W);
    localparam int        DEPTH = TOT / WIDE;
    localparam int        IW    = $clog2(DEPTH);
    localparam int        WAW   = $clog2(TOT / WR_W);
    localparam int        RAW   = $clog2(TOT / RD_W);

    generate
        if (MODE == CFG_BAD) begin : g_bad_cfg
            $error("mwram: width pairing %0d/%0d is not allowed", WR_W, RD_W);
        end
    endgenerate

    logic [IW-1:0]   w_idx;
    logic [IW-1:0]   r_idx;
    logic [WIDE-1:0] w_mask;
    logic [WIDE-1:0] w_bits;
    logic [WIDE-1:0] r_word;

    mwram_wr_lane #(.W(WR_W), .WIDE(WIDE), .AW(WAW), .IW(IW)) u_wr_lane (
        .addr (wr_addr),
        .data (wr_data),
        .idx  (w_idx),
        .mask (w_mask),
        .bits (w_bits)
    );

    mwram_store #(.WIDE(WIDE), .DEPTH(DEPTH), .IW(IW)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en),
        .widx  (w_idx),
        .wmask (w_mask),
        .wbits (w_bits),
        .ridx  (r_idx),
        .rword (r_word)
    );

    mwram_rd_port #(.R(RD_W), .WIDE(WIDE), .AW(RAW), .IW(IW)) u_rd_port (
        .clk   (clk),
        .rst   (rst),
        .re    (rd_en),
        .addr  (rd_addr),
        .idx   (r_idx),
        .rword (r_word),
        .rdata (rd_data)
    );

    AST_MASK_WIDTH: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> ($countones(w_mask) == WR_W)); // R3

endmodule

// File: tb/mwram_pair_tb.sv
`timescale 1ns/1ps
module mwram_pair_tb #(
    parameter int WR_W = 4,
    parameter int RD_W = 16
) (
    input  logic clk,
    output int   n_chk,
    output int   n_err,
    output logic done
);
    localparam int TOT = ((WR_W == 9) || (WR_W == 18)) ? 576 : 512;
    localparam int WD  = TOT / WR_W;
    localparam int RD  = TOT / RD_W;
    localparam int WAW = $clog2(WD);
    localparam int RAW = $clog2(RD);

    logic            rst;
    logic            wr_en;
    logic [WAW-1:0]  wr_addr;
    logic [WR_W-1:0] wr_data;
    logic            rd_en;
    logic [RAW-1:0]  rd_addr;
    logic [RD_W-1:0] rd_data;
    logic [575:0]    ref_bits;
    logic [RD_W-1:0] held;

    mwram #(.WR_W(WR_W), .RD_W(RD_W)) u_dut (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    function automatic logic [WR_W-1:0] pat(input int a, input int p);
        int v;
        v = a * 29 + p * 101 + 7;
        v = v ^ ((a >> 3) * 5);
        return WR_W'(v);
    endfunction

    function automatic logic [RD_W-1:0] ref_rd(input int b);
        return ref_bits[b * RD_W +: RD_W];
    endfunction

    task automatic check(input string req, input logic [RD_W-1:0] act, input logic [RD_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s pair W%0d/R%0d: got %h expected %h", req, WR_W, RD_W, act, exp);
        end
    endtask

    task automatic do_wr(input int a, input logic [WR_W-1:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = WAW'(a);
        wr_data = d;
        rd_en   = 1'b0;
        ref_bits[a * WR_W +: WR_W] = d;
    endtask

    task automatic do_rd(input int b, input string req);
        @(negedge clk);
        wr_en   = 1'b0;
        rd_en   = 1'b1;
        rd_addr = RAW'(b);
        @(negedge clk);
        rd_en = 1'b0;
        check(req, rd_data, ref_rd(b));
    endtask

    initial begin
        int a_last;
        int b_hit;
        logic [RD_W-1:0] old_v;
        n_chk   = 0;
        n_err   = 0;
        done    = 1'b0;
        rst     = 1'b1;
        wr_en   = 1'b0;
        rd_en   = 1'b0;
        wr_addr = '0;
        rd_addr = '0;
        wr_data = '0;
        ref_bits = '0;
        repeat (3) @(negedge clk);
        check("R10", rd_data, '0);
        rst = 1'b0;
        @(negedge clk);
        check("R10", rd_data, '0);

        // R3: full fill at write width, full sweep at read width
        for (int a = 0; a < WD; a++) do_wr(a, pat(a, 0));
        for (int b = 0; b < RD; b++) do_rd(b, "R3");
        // R2: top address of each port
        do_wr(WD - 1, ~pat(WD - 1, 0));
        do_rd(RD - 1, "R2");

        // R5: rewrite only even write addresses, all other bits must survive
        for (int a = 0; a < WD; a += 2) do_wr(a, pat(a, 1));
        for (int b = 0; b < RD; b++) do_rd(b, "R5");

        // R9: same-cycle write and read on overlapping bits
        a_last = WD - 1;
        b_hit  = (a_last * WR_W) / RD_W;
        old_v  = ref_rd(b_hit);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = WAW'(a_last);
        wr_data = ~ref_bits[a_last * WR_W +: WR_W];
        rd_en   = 1'b1;
        rd_addr = RAW'(b_hit);
        ref_bits[a_last * WR_W +: WR_W] = ~ref_bits[a_last * WR_W +: WR_W];
        @(negedge clk);
        wr_en = 1'b0;
        rd_en = 1'b0;
        check("R9", rd_data, old_v);
        do_rd(b_hit, "R9");

        // R4: readback, then R8: hold while bits change and address moves
        do_rd(0, "R4");
        held = ref_rd(0);
        @(negedge clk);
        rd_en   = 1'b0;
        rd_addr = RAW'(RD - 1);
        wr_en   = 1'b1;
        wr_addr = '0;
        wr_data = ~ref_bits[0 +: WR_W];
        ref_bits[0 +: WR_W] = ~ref_bits[0 +: WR_W];
        @(negedge clk);
        wr_en = 1'b0;
        check("R8", rd_data, held);
        @(negedge clk);
        check("R8", rd_data, held);
        do_rd(0, "R4");

        // R6: write enable low with live address and data
        @(negedge clk);
        wr_en   = 1'b0;
        wr_addr = WAW'(WD - 1);
        wr_data = ~ref_bits[(WD - 1) * WR_W +: WR_W];
        @(negedge clk);
        do_rd(((WD - 1) * WR_W) / RD_W, "R6");

        // R7: result visible only after the capturing edge
        held = rd_data;
        @(negedge clk);
        rd_en   = 1'b1;
        rd_addr = '0;
        #1;
        check("R7", rd_data, held);
        @(negedge clk);
        rd_en = 1'b0;
        check("R7", rd_data, ref_rd(0));

        // R10: mid-run reset clears output, stored bits remain
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R10", rd_data, '0);
        do_rd(RD - 1, "R10");

        done = 1'b1;
    end

endmodule

// File: tb/mwram_tb.sv
`timescale 1ns/1ps
module mwram_tb;
    localparam int NP = 27;
    localparam int DW [5] = '{1, 2, 4, 8, 16};
    localparam int AW [7] = '{1, 2, 4, 8, 9, 16, 18};

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    int      chk_a [NP];
    int      err_a [NP];
    logic    done_v [NP];

    generate
        for (genvar i = 0; i < 5; i++) begin : g_w
            for (genvar j = 0; j < 5; j++) begin : g_r
                mwram_pair_tb #(.WR_W(DW[i]), .RD_W(DW[j])) u_pair (
                    .clk   (clk),
                    .n_chk (chk_a[i * 5 + j]),
                    .n_err (err_a[i * 5 + j]),
                    .done  (done_v[i * 5 + j])
                );
            end
        end
    endgenerate

    mwram_pair_tb #(.WR_W(9), .RD_W(9)) u_pair_p9 (
        .clk (clk), .n_chk (chk_a[25]), .n_err (err_a[25]), .done (done_v[25])
    );
    mwram_pair_tb #(.WR_W(18), .RD_W(18)) u_pair_p18 (
        .clk (clk), .n_chk (chk_a[26]), .n_err (err_a[26]), .done (done_v[26])
    );

    initial begin
        int checks;
        int errors;
        int cycles;
        bit all_done;
        checks = 0;
        errors = 0;
        cycles = 0;

        // R1: legality of every width pairing
        for (int i = 0; i < 7; i++) begin
            for (int j = 0; j < 7; j++) begin
                bit w_d;
                bit r_d;
                bit exp_ok;
                bit got_ok;
                w_d = (AW[i] != 9) && (AW[i] != 18);
                r_d = (AW[j] != 9) && (AW[j] != 18);
                exp_ok = (w_d && r_d) || (AW[i] == AW[j]);
                got_ok = mwram_pkg::pair_ok(AW[i], AW[j]);
                checks++;
                if (got_ok !== exp_ok) begin
                    errors++;
                    $display("FAIL R1 pairing %0d/%0d: got %0d expected %0d", AW[i], AW[j], got_ok, exp_ok);
                end
            end
        end

        all_done = 1'b0;
        while (!all_done && cycles < 150000) begin
            @(negedge clk);
            cycles++;
            all_done = 1'b1;
            for (int k = 0; k < NP; k++) if (done_v[k] !== 1'b1) all_done = 1'b0;
        end
        if (!all_done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got %0d cycles expected completion", cycles);
        end
        for (int k = 0; k < NP; k++) begin
            checks += chk_a[k];
            errors += err_a[k];
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule